// File: doc/BRIEF.md
# Ripple-Blanking Fixed-Point Decimal Display Decoder

The block turns a row of BCD digits into active-low seven-segment patterns for a fixed-point decimal readout. By default it has four integer digits and two fractional digits. Every digit has its own BCD-to-segment decoder. A blanking flag passes from stage to stage, so only zeros that add nothing to the value are darkened. On the integer side the flag starts at the most significant digit and moves toward the units digit, which removes leading zeros. On the fractional side it starts at the least significant digit and moves toward the decimal point, which removes trailing zeros. The units digit and the first fractional digit never take part in blanking, so a value of zero still reads "0.0".

A stage darkens its digit only when its own code is zero and the stage before it in the chain asked for blanking. Only then does it pass the request on. A digit that holds a value, or an unused code, ends the run of suppression. An external force-dark input turns off every digit and the decimal point, whatever the digit values are. The decoding is fully combinational. One output register then updates every segment line and the decimal-point line together on each rising clock edge. The digit bus is sampled on every edge. It has no handshake and no back-pressure: whatever the bus holds before an edge is what the display shows after it.

Top module: `rbd_display`

## Requirements
- R1: While reset is asserted (rst_n low), every segment line and the decimal-point line are 1, which means dark.
- R2: Segments are active low. Within digit k, the slice seg_n_o[7k+6:7k] holds a at bit 0 up to g at bit 6. A displayed digit shows the standard decimal glyph. Active-high gfedcba values are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F.
- R3: A BCD code from 10 to 15 shows a dark digit. It counts as non-zero, so it stops the blanking run.
- R4: Digit k sits at digits_i[4k+3:4k]. Digits 0 to FRAC_DIGITS-1 are fractional, with digit 0 the least significant. The next digit is the units digit. Integer digits above the units digit are dark while they and every integer digit above them are zero.
- R5: An integer zero that lies below a displayed or non-zero integer digit is shown.
- R6: The units digit and the most significant fractional digit are never blanked by the chain, so an all-zero input shows "0.0".
- R7: Fractional digits below the most significant one are dark while they and every fractional digit below them are zero. A zero above a non-zero fractional digit is shown.
- R8: When blank_i is 1, every segment line and dp_n_o are 1 after the next clock edge.
- R9: When blank_i is 0, dp_n_o is 0 (lit) after the next clock edge.
- R10: Outputs change only on a rising clock edge. Each edge presents the decode of the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| digits_i | input | 4*(INT_DIGITS+FRAC_DIGITS) | BCD digits; digit 0 is the least significant fractional digit |
| blank_i | input | 1 | Force every digit and the decimal point dark |
| seg_n_o | output | 7*(INT_DIGITS+FRAC_DIGITS) | Active-low segments, 7 per digit, a at the low bit |
| dp_n_o | output | 1 | Active-low decimal point enable |

## Verification
The bench targets zeros at the edges of the suppression runs.

- An all-zero value must read "0.0". A design that lets the chain reach the units digit or the first fractional digit would show an empty display.
- Zeros embedded in "1005" and trailing in "7.50" test the chain direction. A design that blanks every zero, or runs the fractional chain from the decimal point outward, would darken a significant digit or leave a useless zero lit.
- An unused code at the top digit followed by zeros tests R3. A design that treats such a code as zero would swallow the zeros below it.
- Changing the inputs between edges tests R10. A design with a combinational path to the outputs would show the change early.

// File: rtl/rbd_pkg.sv
`timescale 1ns/1ps
package rbd_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = 7'h7F;

  // Active-low glyph, bit 0 = segment a, bit 6 = segment g.
  function automatic seg_t glyph_n(input logic [BCD_W-1:0] code);
    seg_t s;
    case (code)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = SEG_DARK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rbd_digit_stage.sv
`timescale 1ns/1ps
module rbd_digit_stage
  import rbd_pkg::*;
(
  input  logic [BCD_W-1:0] bcd_i,
  input  logic             rb_in_i,
  input  logic             dark_i,
  output seg_t             seg_n_o,
  output logic             rb_out_o
);
  logic is_zero;

  assign is_zero  = (bcd_i == '0);
  assign rb_out_o = rb_in_i & is_zero;
  assign seg_n_o  = (dark_i | rb_out_o) ? SEG_DARK : glyph_n(bcd_i);
endmodule

// File: rtl/rbd_int_chain.sv
`timescale 1ns/1ps
// Integer side: blanking enters at the most significant digit and
// flows down; index 0 is the units digit and never blanks.
module rbd_int_chain
  import rbd_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*BCD_W-1:0] bcd_i,
  input  logic               dark_i,
  output logic [N*SEG_W-1:0] seg_n_o
);
  logic [N:0] rb;
  logic       rb_unused;

  assign rb[N]     = 1'b1;
  assign rb_unused = rb[0];

  for (genvar m = 0; m < N; m++) begin : g_stage
    logic rb_in;
    assign rb_in = (m == 0) ? 1'b0 : rb[m+1];
    rbd_digit_stage u_stage (
      .bcd_i    (bcd_i[m*BCD_W +: BCD_W]),
      .rb_in_i  (rb_in),
      .dark_i   (dark_i),
      .seg_n_o  (seg_n_o[m*SEG_W +: SEG_W]),
      .rb_out_o (rb[m])
    );
  end
endmodule

// File: rtl/rbd_frac_chain.sv
`timescale 1ns/1ps
// Fractional side: blanking enters at the least significant digit and
// flows up; index N-1 sits next to the point and never blanks.
module rbd_frac_chain
  import rbd_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [N*BCD_W-1:0] bcd_i,
  input  logic               dark_i,
  output logic [N*SEG_W-1:0] seg_n_o
);
  logic [N:0] rb;
  logic       rb_unused;

  assign rb[0]     = 1'b1;
  assign rb_unused = rb[N];

  for (genvar j = 0; j < N; j++) begin : g_stage
    logic rb_in;
    assign rb_in = (j == N-1) ? 1'b0 : rb[j];
    rbd_digit_stage u_stage (
      .bcd_i    (bcd_i[j*BCD_W +: BCD_W]),
      .rb_in_i  (rb_in),
      .dark_i   (dark_i),
      .seg_n_o  (seg_n_o[j*SEG_W +: SEG_W]),
      .rb_out_o (rb[j+1])
    );
  end
endmodule

// File: rtl/rbd_out_reg.sv
`timescale 1ns/1ps
module rbd_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '1;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/rbd_display.sv
`timescale 1ns/1ps
module rbd_display
  import rbd_pkg::*;
#(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [(INT_DIGITS+FRAC_DIGITS)*BCD_W-1:0]  digits_i,
  input  logic                                       blank_i,
  output logic [(INT_DIGITS+FRAC_DIGITS)*SEG_W-1:0]  seg_n_o,
  output logic                                       dp_n_o
);
  localparam int DIGITS    = INT_DIGITS + FRAC_DIGITS;
  localparam int FRAC_BUS  = FRAC_DIGITS * BCD_W;
  localparam int FRAC_SEGS = FRAC_DIGITS * SEG_W;
  localparam int SEG_BUS   = DIGITS * SEG_W;
  localparam int REG_W     = SEG_BUS + 1;

  logic [INT_DIGITS*SEG_W-1:0] int_seg;
  logic [FRAC_SEGS-1:0]        frac_seg;
  logic [REG_W-1:0]            next_q;
  logic [REG_W-1:0]            cur_q;

  rbd_int_chain #(.N(INT_DIGITS)) u_int (
    .bcd_i   (digits_i[DIGITS*BCD_W-1:FRAC_BUS]),
    .dark_i  (blank_i),
    .seg_n_o (int_seg)
  );

  rbd_frac_chain #(.N(FRAC_DIGITS)) u_frac (
    .bcd_i   (digits_i[FRAC_BUS-1:0]),
    .dark_i  (blank_i),
    .seg_n_o (frac_seg)
  );

  assign next_q = {blank_i, int_seg, frac_seg};

  rbd_out_reg #(.W(REG_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (next_q),
    .q_o   (cur_q)
  );

  assign dp_n_o  = cur_q[REG_W-1];
  assign seg_n_o = cur_q[SEG_BUS-1:0];
endmodule

// File: rtl/rbd_display_chk.sv
`timescale 1ns/1ps
module rbd_display_chk #(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [(INT_DIGITS+FRAC_DIGITS)*4-1:0] digits_i,
  input logic                                  blank_i,
  input logic [(INT_DIGITS+FRAC_DIGITS)*7-1:0] seg_n_o,
  input logic                                  dp_n_o
);
  localparam int DIGITS = INT_DIGITS + FRAC_DIGITS;
  localparam int MSD    = DIGITS - 1;
  localparam int UNITS  = FRAC_DIGITS;

  p_dark_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> ((&seg_n_o) && dp_n_o));

  p_dp_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |=> !dp_n_o);

  p_units_shown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_i && digits_i[UNITS*4 +: 4] <= 4'd9)
      |=> (seg_n_o[UNITS*7 +: 7] != 7'h7F));

  for (genvar k = 0; k < DIGITS; k++) begin : g_code
    p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank_i && digits_i[k*4 +: 4] > 4'd9) |=> (seg_n_o[k*7 +: 7] == 7'h7F));
  end

  if (INT_DIGITS > 1) begin : g_lead
    p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (digits_i[MSD*4 +: 4] == 4'd0) |=> (seg_n_o[MSD*7 +: 7] == 7'h7F));
  end

  if (FRAC_DIGITS > 1) begin : g_trail
    p_trail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (digits_i[3:0] == 4'd0) |=> (seg_n_o[6:0] == 7'h7F));
  end
endmodule

bind rbd_display rbd_display_chk #(
  .INT_DIGITS  (INT_DIGITS),
  .FRAC_DIGITS (FRAC_DIGITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .digits_i (digits_i),
  .blank_i  (blank_i),
  .seg_n_o  (seg_n_o),
  .dp_n_o   (dp_n_o)
);

// File: tb/rbd_display_tb.sv
`timescale 1ns/1ps
module rbd_display_tb;
  localparam int NI = 4;
  localparam int NF = 2;
  localparam int ND = NI + NF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ND*4-1:0] digits = '0;
  logic            blank = 1'b0;
  logic [ND*7-1:0] seg_n;
  logic            dp_n;
  int              n_checks = 0;
  int              n_fail = 0;

  always #10 clk = ~clk;

  rbd_display #(.INT_DIGITS(NI), .FRAC_DIGITS(NF)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .digits_i (digits),
    .blank_i  (blank),
    .seg_n_o  (seg_n),
    .dp_n_o   (dp_n)
  );

  function automatic logic [6:0] lit(input logic [3:0] v);
    logic [6:0] hi;
    case (v)
      0: hi = 7'h3F; 1: hi = 7'h06; 2: hi = 7'h5B; 3: hi = 7'h4F; 4: hi = 7'h66;
      5: hi = 7'h6D; 6: hi = 7'h7D; 7: hi = 7'h07; 8: hi = 7'h7F; 9: hi = 7'h6F;
      default: hi = 7'h00;
    endcase
    return ~hi;
  endfunction

  function automatic logic [ND*7-1:0] model(input logic [ND*4-1:0] d, input logic b);
    logic [ND*7-1:0] r;
    logic            keep_dark;
    r = '1;
    if (b) return r;
    keep_dark = 1'b1;
    for (int k = ND-1; k >= NF; k--) begin
      if (k == NF || d[k*4 +: 4] != 0) keep_dark = 1'b0;
      if (!keep_dark) r[k*7 +: 7] = lit(d[k*4 +: 4]);
    end
    keep_dark = 1'b1;
    for (int k = 0; k < NF; k++) begin
      if (k == NF-1 || d[k*4 +: 4] != 0) keep_dark = 1'b0;
      if (!keep_dark) r[k*7 +: 7] = lit(d[k*4 +: 4]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [ND*7-1:0] exp_seg, input logic exp_dp);
    n_checks++;
    if (seg_n !== exp_seg || dp_n !== exp_dp) begin
      n_fail++;
      $display("FAIL %s: seg=%h dp=%b expected seg=%h dp=%b", req, seg_n, dp_n, exp_seg, exp_dp);
    end
  endtask

  task automatic apply(input logic [ND*4-1:0] d, input logic b);
    @(negedge clk);
    digits = d;
    blank  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input string req, input logic [ND*4-1:0] d);
    apply(d, 1'b0);
    check(req, model(d, 1'b0), 1'b0);
  endtask

  task automatic t_reset;
    digits = 24'h123456;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset dark", '1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_glyphs;
    for (int v = 1; v <= 9; v++) run("R2 glyph row", {6{v[3:0]}});
    apply(24'h000800, 1'b0);
    check("R2 literal 8 with 0.0 tail", {7'h7F, 7'h7F, 7'h7F, 7'h00, 7'h40, 7'h7F}, 1'b0);
  endtask

  task automatic t_invalid;
    apply(24'hA00000, 1'b0);
    check("R3 bad code stops blanking", {7'h7F, 7'h40, 7'h40, 7'h40, 7'h40, 7'h7F}, 1'b0);
    run("R3 bad codes everywhere", 24'hFEDCBA);
  endtask

  task automatic t_leading;
    apply(24'h001234, 1'b0);
    check("R4 leading zeros dark", {7'h7F, 7'h7F, lit(1), lit(2), lit(3), lit(4)}, 1'b0);
    apply(24'h100500, 1'b0);
    check("R5 embedded zeros shown", {lit(1), lit(0), lit(0), lit(5), lit(0), 7'h7F}, 1'b0);
    run("R5 zero below a digit", 24'h010519);
  endtask

  task automatic t_zero;
    apply(24'h000000, 1'b0);
    check("R6 all zero shows 0.0", {7'h7F, 7'h7F, 7'h7F, lit(0), lit(0), 7'h7F}, 1'b0);
  endtask

  task automatic t_trailing;
    apply(24'h000750, 1'b0);
    check("R7 trailing zero dark", {7'h7F, 7'h7F, 7'h7F, lit(7), lit(5), 7'h7F}, 1'b0);
    apply(24'h000705, 1'b0);
    check("R7 inner fractional zero shown", {7'h7F, 7'h7F, 7'h7F, lit(7), lit(0), lit(5)}, 1'b0);
  endtask

  task automatic t_force;
    apply(24'h987654, 1'b1);
    check("R8 force dark", '1, 1'b1);
    apply(24'h987654, 1'b0);
    check("R9 point lit after release", model(24'h987654, 1'b0), 1'b0);
  endtask

  task automatic t_edge;
    apply(24'h123456, 1'b0);
    @(negedge clk);
    digits = 24'h000100;
    blank  = 1'b1;
    #1;
    check("R10 held between edges", model(24'h123456, 1'b0), 1'b0);
    @(posedge clk);
    #1;
    check("R10 update on edge", '1, 1'b1);
    apply(24'h000100, 1'b0);
    check("R10 next edge decode", model(24'h000100, 1'b0), 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_glyphs();
    t_invalid();
    t_leading();
    t_zero();
    t_trailing();
    t_force();
    t_edge();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule